// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block keeps the timing state of every bank behind one memory channel. For each bank it holds the open row, or none, and three countdowns: one for column commands, one for precharge and one for activate. Each rank also has a spacing timer between activates and a short history of recent activates. Together these enforce a cap on how many activates may fall inside a rolling window.

A command scheduler next to this block reads the per-bank permission flags and then pulses one command strobe with a rank, bank and row. The tracker updates its state at the next clock edge. There are four kinds of command: activate, read, write and precharge. Each bank also counts the column accesses made to its open row. When that count reaches a programmable ceiling, the bank raises a close request.

A strobe that is not permitted leaves all state untouched and sets a sticky error flag. Two or more strobes in the same cycle are treated the same way. The command inputs are plain strobes with no back-pressure: the scheduler is expected to consult the flags before it issues anything.

The flat bank index is rank × BANKS_PER_RANK + bank. Both RANKS and BANKS_PER_RANK must be powers of two. All timing parameters are in clock cycles and must be at least 1. A command issued in cycle t is registered at the edge that ends cycle t, so a delay of D means the matching flag is first high in cycle t+D.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank is closed: `row_valid` is 0, its `open_row` slice reads all ones (the reserved "no row" value), `act_ok` is 1, `col_ok`, `pre_ok` and `close_req` are 0, and `proto_err` is 0.
- R2: A permitted activate in cycle t opens the bank with the given row from cycle t+1. `col_ok` for that bank stays low until cycle t+T_RCD and is high from then on while the row stays open.
- R3: After an activate in cycle t, `pre_ok` for that bank is low until cycle t+T_RAS.
- R4: A permitted precharge in cycle t closes the bank from cycle t+1, and `act_ok` for that bank stays low until cycle t+T_RP.
- R5: After an activate in cycle t, no other bank of the same rank has `act_ok` before cycle t+T_RRD. Banks of other ranks are not affected.
- R6: Within a rank, activate number ACT_LIMIT+1 is blocked until T_XAW cycles have passed since the oldest of the last ACT_LIMIT activates.
- R7: A write in cycle t keeps `pre_ok` low until at least t+T_WR, and a read in cycle t keeps it low until at least t+T_RTP. A later, shorter restriction never shortens a longer one that is still pending.
- R8: Reads and writes to an open row are counted from its activate. `close_req` is high while the row is open and the count is at least `max_row_acc`. A `max_row_acc` of 0 disables close requests.
- R9: A strobe whose permission flag is low, or more than one strobe in a cycle, changes no bank or rank state and sets `proto_err`. `proto_err` stays set until reset.
- R10: Flat bank index rank×BANKS_PER_RANK+bank selects bit positions of the per-bank outputs. Row slice i occupies bits [i×ROW_W +: ROW_W] of `open_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_act | input | 1 | Activate strobe |
| cmd_rd | input | 1 | Read strobe |
| cmd_wr | input | 1 | Write strobe |
| cmd_pre | input | 1 | Precharge strobe |
| cmd_rank | input | RKW | Target rank |
| cmd_bank | input | BKW | Target bank within the rank |
| cmd_row | input | ROW_W | Row opened by an activate |
| max_row_acc | input | ACC_W | Access ceiling before a close request; 0 disables it |
| act_ok | output | NB | Activate permitted, per bank |
| col_ok | output | NB | Read/write permitted, per bank |
| pre_ok | output | NB | Precharge permitted, per bank |
| row_valid | output | NB | Bank has an open row |
| open_row | output | NB×ROW_W | Open row per bank; all ones when closed |
| close_req | output | NB | Access ceiling reached on the open row |
| proto_err | output | 1 | Sticky illegal-command flag |

## Verification
The properties about what an activate, precharge or column command does are qualified on the strobe being single and permitted. This is because illegal strobes are defined to have no effect. The directed stimulus issues at most one strobe per cycle, and it waits out the flags before each legal command. The only exception is the error test, which deliberately violates the rules and then checks at the outputs that nothing moved. Timing checks sweep every cycle around each boundary, not just the cycle where the flag is expected to flip.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int width_for(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/dbt_bank.sv
module dbt_bank #(
  parameter int T_RCD = 3,
  parameter int T_RAS = 8,
  parameter int T_RP  = 3,
  parameter int T_WR  = 6,
  parameter int T_RTP = 2,
  parameter int ROW_W = 8,
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_rd,
  input  logic             do_wr,
  input  logic             do_pre,
  input  logic [ROW_W-1:0] act_row,
  input  logic [ACC_W-1:0] acc_max,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             act_free,
  output logic             is_open,
  output logic [ROW_W-1:0] row_out,
  output logic             close_req
);
  localparam int TMAX = dbt_pkg::max2(dbt_pkg::max2(T_RCD, T_RAS),
                          dbt_pkg::max2(T_RP, dbt_pkg::max2(T_WR, T_RTP)));
  localparam int CW = dbt_pkg::width_for(TMAX);
  localparam logic [CW-1:0] RCD_L = CW'(T_RCD - 1);
  localparam logic [CW-1:0] RAS_L = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_L  = CW'(T_RP - 1);
  localparam logic [CW-1:0] WR_L  = CW'(T_WR - 1);
  localparam logic [CW-1:0] RTP_L = CW'(T_RTP - 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    col_q, pre_q, act_q;
  logic [CW-1:0]    col_dn, pre_dn, act_dn;
  logic [ACC_W-1:0] acc_q;

  assign col_dn = (col_q == '0) ? '0 : col_q - 1'b1;
  assign pre_dn = (pre_q == '0) ? '0 : pre_q - 1'b1;
  assign act_dn = (act_q == '0) ? '0 : act_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '1;
      col_q  <= '0;
      pre_q  <= '0;
      act_q  <= '0;
      acc_q  <= '0;
    end else begin
      col_q <= col_dn;
      pre_q <= pre_dn;
      act_q <= act_dn;
      if (do_act) begin
        open_q <= 1'b1;
        row_q  <= act_row;
        col_q  <= RCD_L;
        pre_q  <= RAS_L;
        acc_q  <= '0;
      end
      if (do_rd || do_wr) begin
        if (do_wr) pre_q <= (pre_dn > WR_L) ? pre_dn : WR_L;
        else       pre_q <= (pre_dn > RTP_L) ? pre_dn : RTP_L;
        if (acc_q != '1) acc_q <= acc_q + 1'b1;
      end
      if (do_pre) begin
        open_q <= 1'b0;
        row_q  <= '1;
        act_q  <= RP_L;
      end
    end
  end

  assign col_ok    = open_q && (col_q == '0);
  assign pre_ok    = open_q && (pre_q == '0);
  assign act_free  = !open_q && (act_q == '0);
  assign is_open   = open_q;
  assign row_out   = row_q;
  assign close_req = open_q && (acc_max != '0) && (acc_q >= acc_max);
endmodule

// File: rtl/dbt_rank_win.sv
module dbt_rank_win #(
  parameter int T_RRD     = 2,
  parameter int T_XAW     = 16,
  parameter int ACT_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  output logic rank_ok
);
  localparam int RRW = dbt_pkg::width_for(T_RRD);
  localparam int AW  = dbt_pkg::width_for(T_XAW);
  localparam logic [RRW-1:0] RRD_L = RRW'(T_RRD - 1);
  localparam logic [AW-1:0]  XAW_L = AW'(T_XAW);

  logic [RRW-1:0] rrd_q;
  logic [AW-1:0]  age_q [ACT_LIMIT];

  function automatic logic [AW-1:0] age_inc(input logic [AW-1:0] a);
    return (a >= XAW_L) ? XAW_L : a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      rrd_q <= '0;
    else if (do_act) rrd_q <= RRD_L;
    else if (rrd_q != '0) rrd_q <= rrd_q - 1'b1;
  end

  for (genvar i = 0; i < ACT_LIMIT; i++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) age_q[i] <= XAW_L;
      else if (do_act) begin
        if (i == 0) age_q[i] <= AW'(1);
        else        age_q[i] <= age_inc(age_q[(i == 0) ? 0 : i-1]);
      end else      age_q[i] <= age_inc(age_q[i]);
    end
  end

  assign rank_ok = (rrd_q == '0) && (age_q[ACT_LIMIT-1] >= XAW_L);
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int RANKS          = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int ROW_W          = 8,
  parameter int ACC_W          = 4,
  parameter int T_RCD          = 3,
  parameter int T_RAS          = 8,
  parameter int T_RP           = 3,
  parameter int T_RRD          = 2,
  parameter int T_XAW          = 16,
  parameter int ACT_LIMIT      = 2,
  parameter int T_WR           = 6,
  parameter int T_RTP          = 2,
  localparam int NB  = RANKS * BANKS_PER_RANK,
  localparam int RKW = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BKW = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_act,
  input  logic                cmd_rd,
  input  logic                cmd_wr,
  input  logic                cmd_pre,
  input  logic [RKW-1:0]      cmd_rank,
  input  logic [BKW-1:0]      cmd_bank,
  input  logic [ROW_W-1:0]    cmd_row,
  input  logic [ACC_W-1:0]    max_row_acc,
  output logic [NB-1:0]       act_ok,
  output logic [NB-1:0]       col_ok,
  output logic [NB-1:0]       pre_ok,
  output logic [NB-1:0]       row_valid,
  output logic [NB*ROW_W-1:0] open_row,
  output logic [NB-1:0]       close_req,
  output logic                proto_err
);
  localparam int GW = (NB > 1) ? $clog2(NB) : 1;

  logic [GW-1:0]    gidx;
  logic [NB-1:0]    bank_free;
  logic [RANKS-1:0] rank_ok;
  logic             single, allowed, legal;

  assign gidx   = GW'(cmd_rank) * GW'(BANKS_PER_RANK) + GW'(cmd_bank);
  assign single = $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre});

  always_comb begin
    allowed = 1'b1;
    if (cmd_act)              allowed = act_ok[gidx];
    else if (cmd_rd || cmd_wr) allowed = col_ok[gidx];
    else if (cmd_pre)         allowed = pre_ok[gidx];
  end
  assign legal = single && allowed;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    dbt_rank_win #(.T_RRD(T_RRD), .T_XAW(T_XAW), .ACT_LIMIT(ACT_LIMIT)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .do_act (legal && cmd_act && (cmd_rank == RKW'(r))),
      .rank_ok(rank_ok[r])
    );
  end

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hit;
    assign hit = legal && (gidx == GW'(i));
    dbt_bank #(.T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_WR(T_WR),
               .T_RTP(T_RTP), .ROW_W(ROW_W), .ACC_W(ACC_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_act   (hit && cmd_act),
      .do_rd    (hit && cmd_rd),
      .do_wr    (hit && cmd_wr),
      .do_pre   (hit && cmd_pre),
      .act_row  (cmd_row),
      .acc_max  (max_row_acc),
      .col_ok   (col_ok[i]),
      .pre_ok   (pre_ok[i]),
      .act_free (bank_free[i]),
      .is_open  (row_valid[i]),
      .row_out  (open_row[i*ROW_W +: ROW_W]),
      .close_req(close_req[i])
    );
    assign act_ok[i] = bank_free[i] && rank_ok[i / BANKS_PER_RANK];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) proto_err <= 1'b0;
    else if ((cmd_act || cmd_rd || cmd_wr || cmd_pre) && !legal) proto_err <= 1'b1;
  end
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int RANKS = 2, parameter int BANKS_PER_RANK = 4,
  parameter int ROW_W = 8, parameter int T_RRD = 2,
  parameter int T_WR = 6,  parameter int T_RTP = 2,
  localparam int NB  = RANKS * BANKS_PER_RANK,
  localparam int RKW = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BKW = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1
) (
  input logic clk, input logic rst_n,
  input logic cmd_act, input logic cmd_rd, input logic cmd_wr, input logic cmd_pre,
  input logic [RKW-1:0] cmd_rank, input logic [BKW-1:0] cmd_bank,
  input logic [ROW_W-1:0] cmd_row,
  input logic [NB-1:0] act_ok, input logic [NB-1:0] col_ok,
  input logic [NB-1:0] pre_ok, input logic [NB-1:0] row_valid,
  input logic [NB*ROW_W-1:0] open_row, input logic proto_err
);
  int unsigned      g, g_nb;
  logic             one;
  int unsigned      g_q, g_nb_q;
  logic [ROW_W-1:0] row_q;

  assign g    = int'(cmd_rank) * BANKS_PER_RANK + int'(cmd_bank);
  assign g_nb = int'(cmd_rank) * BANKS_PER_RANK + ((int'(cmd_bank) + 1) % BANKS_PER_RANK);
  assign one  = $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre});

  always_ff @(posedge clk) begin
    g_q    <= g;
    g_nb_q <= g_nb;
    row_q  <= cmd_row;
  end

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one && cmd_act && act_ok[g]) |=>
      (row_valid[g_q] && open_row[g_q*ROW_W +: ROW_W] == row_q && !act_ok[g_q]));

  // R4
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one && cmd_pre && pre_ok[g]) |=> (!row_valid[g_q] && !col_ok[g_q]));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) !$fell(proto_err));

  if (T_RRD >= 2 && BANKS_PER_RANK > 1) begin : g_rrd
    // R5
    rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (one && cmd_act && act_ok[g]) |=> !act_ok[g_nb_q]);
  end

  if (T_WR >= 2 && T_RTP >= 2) begin : g_rec
    // R7
    col_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (one && (cmd_rd || cmd_wr) && col_ok[g]) |=> !pre_ok[g_q]);
  end
endmodule

bind dram_bank_tracker dbt_checker #(
  .RANKS(RANKS), .BANKS_PER_RANK(BANKS_PER_RANK), .ROW_W(ROW_W),
  .T_RRD(T_RRD), .T_WR(T_WR), .T_RTP(T_RTP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
  .cmd_pre(cmd_pre), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
  .act_ok(act_ok), .col_ok(col_ok), .pre_ok(pre_ok), .row_valid(row_valid),
  .open_row(open_row), .proto_err(proto_err)
);

// File: tb/dram_bank_tracker_tb.sv
`timescale 1ns/1ps
module dram_bank_tracker_tb;
  localparam int NB = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_act = 0, cmd_rd = 0, cmd_wr = 0, cmd_pre = 0;
  logic       cmd_rank = 0;
  logic [1:0] cmd_bank = 0;
  logic [7:0] cmd_row = 0;
  logic [3:0] max_row_acc = 0;
  logic [NB-1:0] act_ok, col_ok, pre_ok, row_valid, close_req;
  logic [NB*8-1:0] open_row;
  logic proto_err;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  dram_bank_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_pre(cmd_pre), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .max_row_acc(max_row_acc), .act_ok(act_ok), .col_ok(col_ok), .pre_ok(pre_ok),
    .row_valid(row_valid), .open_row(open_row), .close_req(close_req),
    .proto_err(proto_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // kind: 0 act, 1 rd, 2 wr, 3 pre; returns at the negedge of cycle t+1
  task automatic issue(input int kind, input int rk, input int bk, input int row);
    cmd_act = (kind == 0); cmd_rd = (kind == 1);
    cmd_wr = (kind == 2);  cmd_pre = (kind == 3);
    cmd_rank = rk[0]; cmd_bank = bk[1:0]; cmd_row = row[7:0];
    @(negedge clk);
    cmd_act = 0; cmd_rd = 0; cmd_wr = 0; cmd_pre = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 row_valid", row_valid, 0);
    check("R1 act_ok", act_ok, 8'hFF);
    check("R1 col_ok", col_ok, 0);
    check("R1 pre_ok", pre_ok, 0);
    check("R1 close_req", close_req, 0);
    check("R1 proto_err", proto_err, 0);
    check("R1 open_row none", open_row[5*8 +: 8], 8'hFF);
  endtask

  task automatic t_act_timing();
    issue(0, 0, 1, 8'h5A);
    check("R2 opened", row_valid[1], 1);
    check("R2 row", open_row[1*8 +: 8], 8'h5A);
    for (int k = 1; k <= 9; k++) begin
      check("R2 col after tRCD", col_ok[1], k >= 3);
      check("R3 pre after tRAS", pre_ok[1], k >= 8);
      @(negedge clk);
    end
  endtask

  task automatic t_precharge();
    issue(3, 0, 1, 0);
    check("R4 closed", row_valid[1], 0);
    check("R1 closed row all ones", open_row[1*8 +: 8], 8'hFF);
    for (int k = 1; k <= 4; k++) begin
      check("R4 act after tRP", act_ok[1], k >= 3);
      @(negedge clk);
    end
  endtask

  task automatic t_rrd();
    idle(20);
    issue(0, 0, 0, 8'h11);
    check("R5 same rank blocked", act_ok[2], 0);
    check("R5 other rank free", act_ok[4], 1);
    @(negedge clk);
    check("R5 same rank after tRRD", act_ok[2], 1);
  endtask

  task automatic t_window();
    issue(0, 1, 0, 8'h21);
    check("R10 flat index rank1 bank0", row_valid[4], 1);
    check("R10 rank0 bank0 untouched row", open_row[0 +: 8], 8'h11);
    @(negedge clk);
    check("R5 rank1 after tRRD", act_ok[5], 1);
    issue(0, 1, 1, 8'h22);
    check("R10 flat index rank1 bank1", row_valid[5], 1);
    for (int k = 1; k <= 15; k++) begin
      check("R6 window limit", act_ok[6], k >= 14);
      @(negedge clk);
    end
  endtask

  task automatic t_recovery();
    idle(20);
    issue(2, 1, 0, 0);
    for (int k = 1; k <= 7; k++) begin
      check("R7 write recovery", pre_ok[4], k >= 6);
      @(negedge clk);
    end
    idle(5);
    issue(2, 1, 0, 0);
    issue(1, 1, 0, 0);
    for (int k = 1; k <= 6; k++) begin
      check("R7 read keeps longer wr wait", pre_ok[4], k >= 5);
      @(negedge clk);
    end
    idle(5);
    issue(1, 1, 0, 0);
    check("R7 read to precharge", pre_ok[4], 0);
    @(negedge clk);
    check("R7 read to precharge done", pre_ok[4], 1);
    check("R8 disabled at zero", close_req[4], 0);
  endtask

  task automatic t_close();
    max_row_acc = 4'd3;
    @(negedge clk);
    check("R8 ceiling on bank 4", close_req[4], 1);
    issue(0, 0, 3, 8'h33);
    idle(2);
    check("R2 col ready", col_ok[3], 1);
    issue(1, 0, 3, 0);
    issue(1, 0, 3, 0);
    check("R8 below ceiling", close_req[3], 0);
    issue(2, 0, 3, 0);
    check("R8 ceiling reached", close_req[3], 1);
    idle(10);
    issue(3, 0, 3, 0);
    check("R8 cleared on close", close_req[3], 0);
    check("R4 closed bank 3", row_valid[3], 0);
  endtask

  task automatic t_illegal();
    check("R9 clean before", proto_err, 0);
    issue(0, 0, 0, 8'h77);
    check("R9 flag set", proto_err, 1);
    check("R9 row unchanged", open_row[0 +: 8], 8'h11);
    issue(1, 0, 3, 0);
    idle(3);
    check("R9 flag sticky", proto_err, 1);
    check("R9 closed bank untouched", row_valid[3], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_act_timing();
    t_precharge();
    t_rrd();
    t_window();
    t_recovery();
    t_close();
    t_illegal();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule